// File: doc/BRIEF.md
# Accumulator Processor Core

This block is a small multi-cycle 8-bit processor with a 64K-byte address space. It has three programmer-visible registers: an 8-bit accumulator, an 8-bit operand register and a one-bit zero flag. Every instruction is a single opcode byte. Loads, stores and jumps take a two-byte address that follows the opcode in memory.

The core drives one byte-wide synchronous memory port, which carries at most one access per clock. Memory and I/O share this port and this address space, so a peripheral is reached with the same load and store instructions as RAM. A read presented in one cycle returns its byte in the next cycle. The program counter and the three registers are brought out as ports so that a surrounding system or a bench can observe them.

Top module: `acc_core`

## Requirements
- R1: While reset is held and just after it is released, the program counter, accumulator, operand register and zero flag are all 0, and the first access is a read of address 0x0000.
- R2: Opcode byte 0x03 copies the accumulator into the operand register, and 0x04 copies the operand register into the accumulator. 0x01 loads the accumulator from the operand address, and 0x02 writes the accumulator to the operand address.
- R3: For opcodes 0x01, 0x02, 0x05, 0x06 and 0x07, the 16-bit address is held in the two bytes that follow the opcode, with the low byte first. The core reads these two bytes in two successive cycles.
- R4: Opcodes 0x08 add, 0x09 subtract (accumulator minus operand register), 0x0A increment, 0x0C AND, 0x0D OR, 0x0E XOR and 0x0F complement write their result to the accumulator. Each of them sets Z to 1 when the result is zero and clears Z otherwise.
- R5: Opcode 0x0B writes 0 to the accumulator and sets Z to 1.
- R6: Opcode 0x05 always jumps to the operand address. 0x06 jumps only when Z is 1, and 0x07 jumps only when Z is 0. A jump that is not taken continues at the byte after the operand.
- R7: Arithmetic wraps modulo 256, and there is no carry.
- R8: Opcodes 0x00 to 0x07 leave Z unchanged.
- R9: Any opcode byte above 0x0F behaves as a no-operation.
- R10: A one-byte instruction takes 2 cycles. A store or a jump takes 4 cycles, and a load takes 5. The write strobe is raised only in the 4th cycle of a store, and a read and a write are never requested together.
- R11: The program that sums 1 to 5 stores 15 at its result address and leaves Z at 1 after its last subtract.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 16 | Address of the memory access |
| mem_rd | output | 1 | Read request; the data is returned on mem_rdata one cycle later |
| mem_wr | output | 1 | Write request for mem_wdata at mem_addr |
| mem_wdata | output | 8 | Data to write |
| mem_rdata | input | 8 | Read data from the previous cycle's read |
| pc_o | output | 16 | Program counter |
| acc_o | output | 8 | Accumulator |
| r_o | output | 8 | Operand register |
| z_o | output | 1 | Zero flag |

## Verification
Each instruction retires a fixed number of rising edges after it starts: 2 for a one-byte instruction, 4 for a store or a jump, and 5 for a load. The bench model counts these edges for every instruction. At the falling edge where the count runs out, it compares PC, AC, R and Z with its own instruction-level result.

On every falling edge in between, the model checks the write strobe. The strobe must be high exactly after the 3rd edge of a store, with the expected address and data, and low at all other times.

Fixed-value checks are tied to particular program addresses. They cover the summing loop, the taken and not-taken branches of both conditional jumps, modulo-256 wrap and an undefined opcode.

// File: rtl/acc_pkg.sv
package acc_pkg;
    localparam int DW = 8;
    localparam int AW = 16;

    typedef enum logic [3:0] {
        OP_NOP  = 4'h0, OP_LDAC = 4'h1, OP_STAC = 4'h2, OP_MVAC = 4'h3,
        OP_MOVR = 4'h4, OP_JUMP = 4'h5, OP_JMPZ = 4'h6, OP_JPNZ = 4'h7,
        OP_ADD  = 4'h8, OP_SUB  = 4'h9, OP_INAC = 4'hA, OP_CLAC = 4'hB,
        OP_AND  = 4'hC, OP_OR   = 4'hD, OP_XOR  = 4'hE, OP_NOT  = 4'hF
    } op_e;

    typedef enum logic [2:0] {
        ST_FETCH, ST_DECODE, ST_ADR_LO, ST_ADR_HI, ST_LOAD
    } state_e;

    typedef struct packed {
        state_e          st;
        op_e             ir;
        logic [AW-1:0]   pc;
        logic [DW-1:0]   acc;
        logic [DW-1:0]   r;
        logic            z;
        logic [DW-1:0]   lo;
    } core_regs_t;
endpackage

// File: rtl/acc_decode.sv
module acc_decode
    import acc_pkg::*;
(
    input  logic [DW-1:0] byte_i,
    output op_e           op_o,
    output logic          has_addr_o
);
    localparam int OPW = 4;

    always_comb begin
        if (byte_i[DW-1:OPW] != '0) op_o = OP_NOP;
        else                        op_o = op_e'(byte_i[OPW-1:0]);
        unique case (op_o)
            OP_LDAC, OP_STAC, OP_JUMP, OP_JMPZ, OP_JPNZ: has_addr_o = 1'b1;
            default:                                     has_addr_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
(
    input  op_e           op_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic [DW-1:0] y_o,
    output logic          zero_o,
    output logic          wr_o
);
    always_comb begin
        wr_o = 1'b1;
        unique case (op_i)
            OP_ADD:  y_o = a_i + b_i;
            OP_SUB:  y_o = a_i - b_i;
            OP_INAC: y_o = a_i + {{(DW-1){1'b0}}, 1'b1};
            OP_CLAC: y_o = '0;
            OP_AND:  y_o = a_i & b_i;
            OP_OR:   y_o = a_i | b_i;
            OP_XOR:  y_o = a_i ^ b_i;
            OP_NOT:  y_o = ~a_i;
            default: begin
                y_o  = a_i;
                wr_o = 1'b0;
            end
        endcase
        zero_o = (y_o == '0);
    end
endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    output logic [15:0]   mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    output logic [15:0]   pc_o,
    output logic [7:0]    acc_o,
    output logic [7:0]    r_o,
    output logic          z_o
);
    core_regs_t q, d;
    op_e           dec_op;
    logic          dec_has_addr;
    logic [DW-1:0] alu_y;
    logic          alu_zero, alu_wr;
    logic [AW-1:0] target;
    logic          take;

    acc_decode u_dec (
        .byte_i     (mem_rdata),
        .op_o       (dec_op),
        .has_addr_o (dec_has_addr)
    );

    acc_alu u_alu (
        .op_i   (dec_op),
        .a_i    (q.acc),
        .b_i    (q.r),
        .y_o    (alu_y),
        .zero_o (alu_zero),
        .wr_o   (alu_wr)
    );

    always_comb begin
        d         = q;
        mem_addr  = q.pc;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_wdata = q.acc;
        target    = {mem_rdata, q.lo};
        take      = (q.ir == OP_JUMP) ||
                    (q.ir == OP_JMPZ &&  q.z) ||
                    (q.ir == OP_JPNZ && !q.z);
        unique case (q.st)
            ST_FETCH: begin
                mem_rd = 1'b1;
                d.pc   = q.pc + 1'b1;
                d.st   = ST_DECODE;
            end
            ST_DECODE: begin
                d.ir = dec_op;
                if (dec_has_addr) begin
                    mem_rd = 1'b1;
                    d.pc   = q.pc + 1'b1;
                    d.st   = ST_ADR_LO;
                end else begin
                    d.st = ST_FETCH;
                    if (dec_op == OP_MVAC) d.r   = q.acc;
                    if (dec_op == OP_MOVR) d.acc = q.r;
                    if (alu_wr) begin
                        d.acc = alu_y;
                        d.z   = alu_zero;
                    end
                end
            end
            ST_ADR_LO: begin
                d.lo   = mem_rdata;
                mem_rd = 1'b1;
                d.pc   = q.pc + 1'b1;
                d.st   = ST_ADR_HI;
            end
            ST_ADR_HI: begin
                d.st = ST_FETCH;
                if (q.ir == OP_LDAC) begin
                    mem_addr = target;
                    mem_rd   = 1'b1;
                    d.st     = ST_LOAD;
                end else if (q.ir == OP_STAC) begin
                    mem_addr = target;
                    mem_wr   = 1'b1;
                end else if (take) begin
                    d.pc = target;
                end
            end
            ST_LOAD: begin
                d.acc = mem_rdata;
                d.st  = ST_FETCH;
            end
            default: d.st = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_FETCH, ir: OP_NOP, pc: '0, acc: '0, r: '0, z: 1'b0, lo: '0};
        end else begin
            q <= d;
        end
    end

    assign pc_o  = q.pc;
    assign acc_o = q.acc;
    assign r_o   = q.r;
    assign z_o   = q.z;

    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R10
    AST_WRITE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> (q.st == ST_FETCH)); // R10
    AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FETCH) |=> (q.pc == $past(q.pc) + 16'd1)); // R10
    AST_CLAC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DECODE && dec_op == OP_CLAC) |=> (q.acc == '0 && q.z)); // R5
    AST_Z_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_DECODE) |=> $stable(q.z)); // R8
    AST_LOAD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_LOAD) |=> (q.acc == $past(mem_rdata))); // R3
endmodule

// File: tb/acc_core_test.sv
module acc_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;
    logic [15:0] pc_o;
    logic [7:0]  acc_o, r_o;
    logic        z_o;

    int checks = 0;
    int fails  = 0;

    logic [7:0] mem     [0:1023];
    logic [7:0] ref_mem [0:1023];

    logic [15:0] m_pc = 16'h0000;
    logic [7:0]  m_ac = 8'h00, m_r = 8'h00;
    logic        m_z = 1'b0;
    int          m_op = 0;
    int          m_cyc = 0;
    logic [15:0] w_addr = 16'h0000;
    logic [7:0]  w_data = 8'h00;

    always #5 clk = ~clk;

    acc_core uut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .pc_o(pc_o), .acc_o(acc_o), .r_o(r_o), .z_o(z_o)
    );

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic poke(input int a, input int v);
        mem[a]     = 8'(v);
        ref_mem[a] = 8'(v);
    endtask

    task automatic poke3(input int a, input int op, input int tgt);
        poke(a, op);
        poke(a + 1, tgt & 255);
        poke(a + 2, tgt >> 8);
    endtask

    task automatic model_step();
        logic [15:0] tgt;
        logic [7:0]  raw;
        raw  = ref_mem[m_pc[9:0]];
        tgt  = {ref_mem[10'(m_pc + 16'd2)], ref_mem[10'(m_pc + 16'd1)]};
        m_op = (raw > 8'h0F) ? 0 : int'(raw);
        m_cyc = 2;
        case (m_op)
            1: begin m_ac = ref_mem[tgt[9:0]]; m_cyc = 5; end
            2: begin ref_mem[tgt[9:0]] = m_ac; w_addr = tgt; w_data = m_ac; m_cyc = 4; end
            3: m_r = m_ac;
            4: m_ac = m_r;
            5, 6, 7: m_cyc = 4;
            8: m_ac = m_ac + m_r;
            9: m_ac = m_ac - m_r;
            10: m_ac = m_ac + 8'd1;
            11: m_ac = 8'd0;
            12: m_ac = m_ac & m_r;
            13: m_ac = m_ac | m_r;
            14: m_ac = m_ac ^ m_r;
            15: m_ac = ~m_ac;
            default: ;
        endcase
        if (m_op >= 8) m_z = (m_ac == 8'd0);
        if (m_op == 5 || (m_op == 6 && m_z) || (m_op == 7 && !m_z)) m_pc = tgt;
        else if (m_op == 1 || m_op == 2 || m_op >= 5 && m_op <= 7) m_pc = m_pc + 16'd3;
        else m_pc = m_pc + 16'd1;
    endtask

    task automatic point_checks();
        case (m_pc)
            16'd29: begin
                check(z_o == 1'b1 && acc_o == 8'd0, "R11 Z after last SUB", {acc_o, 7'd0, z_o}, 16'h0001);
                check(mem[10'h200] == 8'd15, "R11 sum stored", mem[10'h200], 15);
            end
            16'd31:  check(acc_o == 8'd5 && r_o == 8'd5 && z_o, "R8 R9 MOVR and 0x5A keep Z", {acc_o, 7'd0, z_o}, 16'h0501);
            16'd32:  check(acc_o == 8'hFA && !z_o, "R4 NOT", {acc_o, 7'd0, z_o}, 16'hFA00);
            16'd35:  check(pc_o == 16'd35, "R6 JMPZ not taken", pc_o, 35);
            16'd42:  check(acc_o == 8'h00 && z_o, "R4 XOR zero", {acc_o, 7'd0, z_o}, 16'h0001);
            16'h123: check(pc_o == 16'h0123, "R3 R6 JMPZ taken low byte first", pc_o, 16'h0123);
            16'h134: check(acc_o == 8'h00 && z_o, "R7 ADD wraps", {acc_o, 7'd0, z_o}, 16'h0001);
            16'h13A: check(pc_o == 16'h013A, "R6 JPNZ not taken", pc_o, 16'h013A);
            16'h13C: check(acc_o == 8'h06 && !z_o, "R7 SUB wraps", {acc_o, 7'd0, z_o}, 16'h0600);
            16'h13D: check(acc_o == 8'h00 && z_o, "R5 CLAC", {acc_o, 7'd0, z_o}, 16'h0001);
            default: ;
        endcase
    endtask

    initial begin
        int k = 0;
        int halts = 0;
        int cycles = 0;
        bit timeout = 1'b0;
        for (int i = 0; i < 1024; i++) poke(i, 0);
        poke(0, 8'h0B);
        poke3(1, 2, 16'h0200);
        poke3(4, 2, 16'h0201);
        poke3(7, 1, 16'h0201);
        poke(10, 8'h0A);
        poke3(11, 2, 16'h0201);
        poke(14, 8'h03);
        poke3(15, 1, 16'h0200);
        poke(18, 8'h08);
        poke3(19, 2, 16'h0200);
        poke3(22, 1, 16'h0202);
        poke(25, 8'h09);
        poke3(26, 7, 16'h0007);
        poke(29, 8'h04);
        poke(30, 8'h5A);
        poke(31, 8'h0F);
        poke3(32, 6, 16'h0100);
        poke(35, 8'h03);
        poke3(36, 1, 16'h0203);
        poke(39, 8'h0C);
        poke(40, 8'h0D);
        poke(41, 8'h0E);
        poke3(42, 6, 16'h0123);
        poke(16'h123, 8'h0A);
        poke3(16'h124, 7, 16'h0130);
        poke3(16'h130, 1, 16'h0204);
        poke(16'h133, 8'h08);
        poke3(16'h134, 2, 16'h0205);
        poke3(16'h137, 7, 16'h0000);
        poke(16'h13A, 8'h09);
        poke(16'h13B, 8'h00);
        poke(16'h13C, 8'h0B);
        poke3(16'h13D, 5, 16'h013D);
        poke(16'h202, 5);
        poke(16'h203, 8'h3C);
        poke(16'h204, 8'h06);
        poke(16'h205, 8'hEE);

        repeat (3) @(negedge clk);
        check(pc_o == 0 && acc_o == 0 && r_o == 0 && !z_o, "R1 reset state", {pc_o, acc_o}, 0);
        check(mem_rd && mem_addr == 16'h0000 && !mem_wr, "R1 first fetch", mem_addr, 0);
        rst_n = 1'b1;

        forever begin
            if (k == m_cyc) begin
                check(pc_o == m_pc, "R2 R10 pc at retire", pc_o, m_pc);
                check(acc_o == m_ac && r_o == m_r && z_o == m_z, "R2 R4 R8 registers",
                      {acc_o, r_o, 7'd0, z_o}, {m_ac, m_r, 7'd0, m_z});
                point_checks();
                if (m_pc == 16'h013D) halts++;
                if (halts == 3) break;
                model_step();
                k = 0;
            end
            if (m_op == 2 && k == 3)
                check(mem_wr && mem_addr == w_addr && mem_wdata == w_data, "R10 store strobe",
                      {mem_wr, mem_addr, mem_wdata}, {1'b1, w_addr, w_data});
            else
                check(!mem_wr, "R10 no stray write", mem_wr, 0);
            k++;
            cycles++;
            if (cycles > 20000) begin timeout = 1'b1; break; end
            @(negedge clk);
        end

        check(!timeout, "R10 watchdog", cycles, 20000);
        check(mem[10'h200] == 8'd15, "R11 total", mem[10'h200], 15);
        check(mem[10'h201] == 8'd5, "R2 loop index", mem[10'h201], 5);
        check(mem[10'h205] == 8'd0, "R2 R7 stored wrap", mem[10'h205], 0);
        for (int i = 0; i < 1024; i++)
            if (mem[i] != ref_mem[i]) check(1'b0, "R2 memory image", mem[i], ref_mem[i]);
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule